// File: doc/BRIEF.md
# Multicart PRG Bank Translator

This block turns the upper bits of a CPU address in the 0x6000 to 0xFFFF range into an 8 KB bank number for the cartridge program memory. A multicart board places an outer banking layer over a standard inner mapper. The inner mapper supplies one 8 KB bank value for each of the four ROM windows and a work-RAM page number. A small set of outer registers picks how those values are combined: one 32 KB bank, one 16 KB bank mirrored in both halves, or the inner 8 KB banks confined to an outer block.

The inner 8 KB mode keeps fewer inner bank bits as the mode value grows, and places the outer register above them. Mode 0 uses a fixed mask instead, and one board-variant input selects how wide that mask is. An extension enable can replace the two upper ROM windows with two direct bank values. The result goes through one output register. A valid flag shows when the address hits a mapped window, and a select flag shows whether that window is ROM or work RAM.

Top module: `prg_bank_xlat`

## Requirements
- R1: While rst_n is low, bank_out, ram_sel and map_valid are all 0.
- R2: Outputs are registered. A change on any input is visible on the outputs after the next rising clock edge and not before it.
- R3: For cpu_page 0 to 2 (address below 0x6000), map_valid=0, ram_sel=0 and bank_out=0.
- R4: For cpu_page 3 (0x6000 to 0x7FFF), map_valid=1, ram_sel=1 and bank_out equals ram_page, zero-extended. mode_sel has no effect on this window.
- R5: With mode_sel=4, ROM windows map one 32 KB bank: bank_out = {outer_bank[7:1], cpu_page[1:0]}.
- R6: With mode_sel=3, the 16 KB bank outer_bank appears at 0x8000 and again at 0xC000: bank_out = {outer_bank, cpu_page[0]}.
- R7: With mode_sel[1:0] nonzero and mode_sel not 3 or 4 (values 1, 2, 5, 6, 7), the window's inner bank keeps its low (6 - mode_sel[1:0]) bits, and outer_bank shifted left by one is ORed in.
- R8: With mode_sel 0, the inner bank is ANDed with 0x7F when wiring_alt=0 and with 0x3F when wiring_alt=1. outer_bank is not used.
- R9: In the modes of R7 and R8, when ext_en=1 the 0xC000 and 0xE000 windows (cpu_page 6 and 7) output ext_bank_c and ext_bank_e unmasked. ext_en has no effect in modes 3 and 4, and none on the 0x8000 and 0xA000 windows.
- R10: For cpu_page 4 to 7, map_valid=1 and ram_sel=0. cpu_page[1:0] selects the inner bank input, in the order 8000, A000, C000, E000.

Ports are numbered from bank 0, in 8 KB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_page | input | 3 | CPU address bits 15..13 |
| mode_sel | input | 3 | Outer banking mode |
| outer_bank | input | 8 | Outer bank / block register |
| ext_en | input | 1 | Extended upper-window banking enable |
| ext_bank_c | input | 8 | Direct bank for 0xC000 window |
| ext_bank_e | input | 8 | Direct bank for 0xE000 window |
| inner_bank_8 | input | 8 | Inner mapper bank for 0x8000 |
| inner_bank_a | input | 8 | Inner mapper bank for 0xA000 |
| inner_bank_c | input | 8 | Inner mapper bank for 0xC000 |
| inner_bank_e | input | 8 | Inner mapper bank for 0xE000 |
| ram_page | input | 2 | Inner mapper work-RAM page |
| wiring_alt | input | 1 | Board variant: narrows the mode 0 mask |
| bank_out | output | 9 | Physical 8 KB bank number |
| ram_sel | output | 1 | 1 = work RAM, 0 = ROM |
| map_valid | output | 1 | Address falls in a mapped window |

## Verification
Every result arrives exactly one rising edge after its inputs change, because the only register on the path is the output stage. The bench drives all inputs on a falling edge and samples on the following falling edge, which is half a period after the register loads. For R2 it also samples a quarter period after a change, before any rising edge, and expects the old value to still be present. The sweep covers every mode, both wiring variants, both ext_en settings, all four ROM windows and several outer-register values. It also checks the RAM window and the unmapped pages.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;
  // ROM window slot order inside 0x8000..0xFFFF
  typedef enum logic [1:0] {
    SLOT_8000 = 2'd0,
    SLOT_A000 = 2'd1,
    SLOT_C000 = 2'd2,
    SLOT_E000 = 2'd3
  } slot_t;

  localparam logic [2:0] MODE_INNER0 = 3'd0;
  localparam logic [2:0] MODE_HALF   = 3'd3;
  localparam logic [2:0] MODE_FULL   = 3'd4;
  localparam logic [2:0] PAGE_RAM    = 3'd3;
endpackage

// File: rtl/prg_win_decode.sv
module prg_win_decode
  import prg_xlat_pkg::*;
(
  input  logic [2:0] page,
  output logic       is_ram,
  output logic       is_rom,
  output slot_t      slot
);
  always_comb begin
    is_ram = (page == PAGE_RAM);
    is_rom = page[2];
    slot   = slot_t'(page[1:0]);
  end
endmodule

// File: rtl/prg_inner_bank.sv
module prg_inner_bank
  import prg_xlat_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int INNER_SPAN = 6,
  localparam int BANK_W    = REG_W + 1,
  localparam int SH_W      = $clog2(REG_W + 1)
) (
  input  logic [2:0]        mode,
  input  logic              wiring_alt,
  input  logic [REG_W-1:0]  inner_val,
  input  logic [REG_W-1:0]  outer_val,
  output logic [BANK_W-1:0] bank
);
  localparam logic [REG_W-1:0] ONES = '1;
  localparam logic [SH_W-1:0]  SPAN = SH_W'(INNER_SPAN);

  logic [REG_W-1:0] keep;
  logic [SH_W-1:0]  shamt;

  always_comb begin
    shamt = SPAN - SH_W'(mode[1:0]);
    if (mode[1:0] == 2'd0) begin
      keep = wiring_alt ? (ONES >> 2) : (ONES >> 1);
      bank = {1'b0, inner_val & keep};
    end else begin
      keep = ~(ONES << shamt);
      bank = {1'b0, inner_val & keep} | {outer_val, 1'b0};
    end
  end
endmodule

// File: rtl/prg_rom_select.sv
module prg_rom_select
  import prg_xlat_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int INNER_SPAN = 6,
  localparam int BANK_W    = REG_W + 1,
  localparam int SLOTS     = 4
) (
  input  logic [2:0]                  mode,
  input  logic                        wiring_alt,
  input  slot_t                       slot,
  input  logic [REG_W-1:0]            outer_val,
  input  logic                        ext_en,
  input  logic [REG_W-1:0]            ext_c,
  input  logic [REG_W-1:0]            ext_e,
  input  logic [SLOTS-1:0][REG_W-1:0] inner_vals,
  output logic [BANK_W-1:0]           bank
);
  logic [SLOTS-1:0][BANK_W-1:0] slot_bank;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    prg_inner_bank #(.REG_W(REG_W), .INNER_SPAN(INNER_SPAN)) u_inner (
      .mode       (mode),
      .wiring_alt (wiring_alt),
      .inner_val  (inner_vals[s]),
      .outer_val  (outer_val),
      .bank       (slot_bank[s])
    );
  end

  always_comb begin
    if (mode == MODE_FULL)
      bank = {outer_val[REG_W-1:1], slot};
    else if (mode == MODE_HALF)
      bank = {outer_val, slot[0]};
    else if (ext_en && slot == SLOT_C000)
      bank = {1'b0, ext_c};
    else if (ext_en && slot == SLOT_E000)
      bank = {1'b0, ext_e};
    else
      bank = slot_bank[slot];
  end
endmodule

// File: rtl/prg_bank_xlat.sv
module prg_bank_xlat
  import prg_xlat_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int INNER_SPAN = 6,
  parameter int RAM_PG_W   = 2,
  localparam int BANK_W    = REG_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cpu_page,
  input  logic [2:0]          mode_sel,
  input  logic [REG_W-1:0]    outer_bank,
  input  logic                ext_en,
  input  logic [REG_W-1:0]    ext_bank_c,
  input  logic [REG_W-1:0]    ext_bank_e,
  input  logic [REG_W-1:0]    inner_bank_8,
  input  logic [REG_W-1:0]    inner_bank_a,
  input  logic [REG_W-1:0]    inner_bank_c,
  input  logic [REG_W-1:0]    inner_bank_e,
  input  logic [RAM_PG_W-1:0] ram_page,
  input  logic                wiring_alt,
  output logic [BANK_W-1:0]   bank_out,
  output logic                ram_sel,
  output logic                map_valid
);
  logic        is_ram, is_rom;
  slot_t       slot;
  logic [BANK_W-1:0] rom_bank;
  logic [3:0][REG_W-1:0] inner_vals;

  logic [BANK_W-1:0] bank_d;
  logic              ram_d, valid_d;

  assign inner_vals = {inner_bank_e, inner_bank_c, inner_bank_a, inner_bank_8};

  prg_win_decode u_dec (
    .page   (cpu_page),
    .is_ram (is_ram),
    .is_rom (is_rom),
    .slot   (slot)
  );

  prg_rom_select #(.REG_W(REG_W), .INNER_SPAN(INNER_SPAN)) u_rom (
    .mode       (mode_sel),
    .wiring_alt (wiring_alt),
    .slot       (slot),
    .outer_val  (outer_bank),
    .ext_en     (ext_en),
    .ext_c      (ext_bank_c),
    .ext_e      (ext_bank_e),
    .inner_vals (inner_vals),
    .bank       (rom_bank)
  );

  always_comb begin
    bank_d  = '0;
    ram_d   = 1'b0;
    valid_d = 1'b0;
    if (is_ram) begin
      bank_d  = BANK_W'(ram_page);
      ram_d   = 1'b1;
      valid_d = 1'b1;
    end else if (is_rom) begin
      bank_d  = rom_bank;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_out  <= '0;
      ram_sel   <= 1'b0;
      map_valid <= 1'b0;
    end else begin
      bank_out  <= bank_d;
      ram_sel   <= ram_d;
      map_valid <= valid_d;
    end
  end
endmodule

// File: rtl/prg_bank_xlat_chk.sv
module prg_bank_xlat_chk #(
  parameter int REG_W    = 8,
  parameter int RAM_PG_W = 2,
  localparam int BANK_W  = REG_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          cpu_page,
  input logic [2:0]          mode_sel,
  input logic [REG_W-1:0]    outer_bank,
  input logic [RAM_PG_W-1:0] ram_page,
  input logic [BANK_W-1:0]   bank_out,
  input logic                ram_sel,
  input logic                map_valid
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (bank_out == '0 && !ram_sel && !map_valid);
    end
  end

  // R3
  low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ($past(cpu_page) < 3'd3) |-> (!map_valid && !ram_sel && bank_out == '0));

  // R4
  ram_win_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ($past(cpu_page) == 3'd3) |-> (map_valid && ram_sel && bank_out == BANK_W'($past(ram_page))));

  // R10
  rom_sel_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(cpu_page[2]) |-> (map_valid && !ram_sel));

  // R5
  full_bank_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ($past(cpu_page[2]) && $past(mode_sel) == 3'd4)
      |-> (bank_out == {$past(outer_bank[REG_W-1:1]), $past(cpu_page[1:0])}));

  // R6
  half_bank_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ($past(cpu_page[2]) && $past(mode_sel) == 3'd3)
      |-> (bank_out == {$past(outer_bank), $past(cpu_page[0])}));

  // R10
  sel_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> map_valid);
endmodule

bind prg_bank_xlat prg_bank_xlat_chk #(.REG_W(REG_W), .RAM_PG_W(RAM_PG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_page   (cpu_page),
  .mode_sel   (mode_sel),
  .outer_bank (outer_bank),
  .ram_page   (ram_page),
  .bank_out   (bank_out),
  .ram_sel    (ram_sel),
  .map_valid  (map_valid)
);

// File: tb/tb_prg_bank_xlat.sv
module tb_prg_bank_xlat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cpu_page = '0;
  logic [2:0] mode_sel = '0;
  logic [7:0] outer_bank = '0;
  logic       ext_en = 1'b0;
  logic [7:0] ext_bank_c = '0;
  logic [7:0] ext_bank_e = '0;
  logic [7:0] inner_bank_8 = '0;
  logic [7:0] inner_bank_a = '0;
  logic [7:0] inner_bank_c = '0;
  logic [7:0] inner_bank_e = '0;
  logic [1:0] ram_page = '0;
  logic       wiring_alt = 1'b0;
  logic [8:0] bank_out;
  logic       ram_sel, map_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  prg_bank_xlat dut (
    .clk(clk), .rst_n(rst_n), .cpu_page(cpu_page), .mode_sel(mode_sel),
    .outer_bank(outer_bank), .ext_en(ext_en), .ext_bank_c(ext_bank_c),
    .ext_bank_e(ext_bank_e), .inner_bank_8(inner_bank_8),
    .inner_bank_a(inner_bank_a), .inner_bank_c(inner_bank_c),
    .inner_bank_e(inner_bank_e), .ram_page(ram_page), .wiring_alt(wiring_alt),
    .bank_out(bank_out), .ram_sel(ram_sel), .map_valid(map_valid)
  );

  function automatic int exp_bank();
    int win, v, bits;
    if (cpu_page < 3) return 0;
    if (cpu_page == 3) return int'(ram_page);
    win = int'(cpu_page) - 4;
    if (mode_sel == 4) return (int'(outer_bank) / 2) * 4 + win;
    if (mode_sel == 3) return int'(outer_bank) * 2 + (win % 2);
    if (ext_en && win == 2) return int'(ext_bank_c);
    if (ext_en && win == 3) return int'(ext_bank_e);
    case (win)
      0: v = int'(inner_bank_8);
      1: v = int'(inner_bank_a);
      2: v = int'(inner_bank_c);
      default: v = int'(inner_bank_e);
    endcase
    if (mode_sel % 4 != 0) begin
      bits = 6 - int'(mode_sel % 4);
      return (v % (1 << bits)) | (int'(outer_bank) * 2);
    end
    return v & (wiring_alt ? 63 : 127);
  endfunction

  function automatic string req_tag();
    if (cpu_page < 3) return "R3";
    if (cpu_page == 3) return "R4";
    if (mode_sel == 4) return "R5";
    if (mode_sel == 3) return "R6";
    if (ext_en && cpu_page[1]) return "R9";
    if (mode_sel % 4 != 0) return "R7";
    return "R8";
  endfunction

  task automatic check_out(string tag, int eb, bit er, bit ev);
    checks++;
    if (int'(bank_out) != eb || ram_sel != er || map_valid != ev) begin
      fails++;
      $display("FAIL %s: got bank=%0d ram=%0b valid=%0b, expected bank=%0d ram=%0b valid=%0b",
               tag, bank_out, ram_sel, map_valid, eb, er, ev);
    end
  endtask

  task automatic check_cur();
    bit ev, er;
    ev = (cpu_page >= 3);
    er = (cpu_page == 3);
    @(negedge clk);
    check_out(req_tag(), exp_bank(), er, ev);
    // R10: ROM pages must report valid and not RAM (covered by ev/er above)
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    byte unsigned outers[4] = '{8'h00, 8'hA5, 8'hFF, 8'h3C};
    cpu_page = 3'd7; mode_sel = 3'd4; outer_bank = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check_out("R1", 0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: registered path, old value until the next rising edge
    cpu_page = 3'd4; mode_sel = 3'd4; outer_bank = 8'h10;
    @(negedge clk);
    check_out("R2", 32, 1'b0, 1'b1);
    cpu_page = 3'd5;
    #1.25;
    check_out("R2", 32, 1'b0, 1'b1);
    @(negedge clk);
    check_out("R2", 33, 1'b0, 1'b1);

    // R3, R4: unmapped pages and RAM window across modes and pages
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 4; p++) begin
        mode_sel = 3'(m); cpu_page = 3'(p); ram_page = 2'(p + m);
        outer_bank = 8'hFF; ext_en = 1'b1;
        check_cur();
      end
    end

    // R5..R10 sweep
    inner_bank_8 = 8'hFF; inner_bank_a = 8'h5A;
    inner_bank_c = 8'hC3; inner_bank_e = 8'h81;
    ext_bank_c = 8'hE7; ext_bank_e = 8'h92;
    for (int m = 0; m < 8; m++)
      for (int w = 0; w < 2; w++)
        for (int x = 0; x < 2; x++)
          for (int o = 0; o < 4; o++)
            for (int p = 4; p < 8; p++) begin
              mode_sel = 3'(m); wiring_alt = w[0]; ext_en = x[0];
              outer_bank = outers[o]; cpu_page = 3'(p);
              check_cur();
            end

    // R8: wiring boundary with all-ones inner bank
    mode_sel = 3'd0; ext_en = 1'b0; cpu_page = 3'd4; inner_bank_8 = 8'hFF;
    wiring_alt = 1'b0; @(negedge clk); check_out("R8", 127, 1'b0, 1'b1);
    wiring_alt = 1'b1; @(negedge clk); check_out("R8", 63, 1'b0, 1'b1);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0; #1; check_out("R1", 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule